// File: doc/BRIEF.md
# DMA Channel Control Registers

This block holds the four 32-bit word registers that steer one DMA channel serving a peripheral controller: a control/status word, a memory address word and two spare words. It sits in a 16-byte window, and the word is picked by the byte address bits 3:2. A control write is not stored exactly as written. The top nibble always reads back as a fixed version code. Bit 7 fires a one-cycle reset pulse toward the peripheral. Bit 6 and an all-zero value get special handling.

The control word also tracks the peripheral's interrupt. A raise strobe sets a pending flag and an acknowledge strobe clears it. The interrupt output is the pending flag gated by an enable bit. Each write to the address word marks the channel as loaded. The address word advances by the length of each transfer chunk that the memory-side master reports as done.

Top module: `dmach_regs`

## Requirements
- R1: After reset all four words read 0, and `irq`, `periph_rst`, `dir_to_mem` and `loaded` are 0.
- R2: A write to word 0 stores bits 27:0 from the written data, subject to R3, and bits 31:28 read back as 0xA.
- R3: For a word-0 write, the first matching rule applies. Bit 7 set: `periph_rst` is high for exactly the one cycle after the write, and the value is stored with bit 6 as written. Bit 7 clear and bit 6 set: bit 6 is stored as 0. Written value exactly 0: the word stores 0xA0000040.
- R4: Control bit 0 is the pending flag. An `irq_raise` strobe sets it on the next edge and an `irq_ack` strobe clears it. If both strobes come together, the flag is set. Either strobe overrides bit 0 of a word-0 write in the same cycle. With no strobe, a write stores bit 0 as written.
- R5: `irq` is high exactly when control bit 0 and control bit 4 (enable) are both 1. A word-0 write with bit 4 clear therefore drops `irq` from the cycle after the write.
- R6: Any write to word 1 stores the data there and sets control bit 26. All other control bits keep their value.
- R7: `dir_to_mem` shows control bit 8 (1 means the channel writes to memory, 0 means it reads memory toward the device). `loaded` shows control bit 26.
- R8: A `xfer_done` strobe adds the zero-extended `xfer_len` to word 1, wrapping at 32 bits. A word-1 write in the same cycle wins and the advance is dropped.
- R9: Words 2 and 3 store data exactly as written. Reads return the addressed word combinationally, ignore address bits 1:0 and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Write strobe for the word selected by `addr` |
| addr | input | 4 | Byte address in the window; word index is bits 3:2 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Data of the addressed word |
| irq_raise | input | 1 | Peripheral interrupt request strobe |
| irq_ack | input | 1 | Peripheral interrupt acknowledge strobe |
| xfer_done | input | 1 | A transfer chunk has completed |
| xfer_len | input | LEN_W | Length of the completed chunk |
| irq | output | 1 | Gated interrupt to the host |
| periph_rst | output | 1 | One-cycle reset pulse to the peripheral |
| dir_to_mem | output | 1 | Transfer direction, control bit 8 |
| loaded | output | 1 | Address word written, control bit 26 |

## Verification
Two pairs of functions can land in the same cycle. One pair is a control write and an interrupt strobe, since both update control bit 0. The other is a word-1 write and a transfer-done strobe, since both update the address word. The bench drives each pair on the same edge, including raise and acknowledge together. It judges the outcome by reading the words back and by watching `irq` on the following cycles. A behavioural model applies the priority rules of R4 and R8, and the `irq`, `periph_rst`, `dir_to_mem` and `loaded` outputs are compared against it on every clock.

// File: rtl/dmach_regs.sv
module dmach_regs #(
  parameter int       LEN_W = 16,
  parameter bit [3:0] VER   = 4'hA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [3:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic             irq_raise,
  input  logic             irq_ack,
  input  logic             xfer_done,
  input  logic [LEN_W-1:0] xfer_len,
  output logic             irq,
  output logic             periph_rst,
  output logic             dir_to_mem,
  output logic             loaded
);
  localparam int PAD = 32 - LEN_W;

  logic [31:0] ctrl_q, addr_q, sp2_q, sp3_q;
  logic        rst_q;
  logic [1:0]  idx;
  logic [31:0] ctrl_wv, ctrl_d;
  logic        unused_lo;

  assign idx       = addr[3:2];
  assign unused_lo = ^addr[1:0];

  always_comb begin
    ctrl_wv = wdata;
    if (!wdata[7]) begin
      if (wdata[6])          ctrl_wv[6] = 1'b0;
      else if (wdata == '0)  ctrl_wv     = 32'h40;
    end
    ctrl_wv[31:28] = VER;
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (we && idx == 2'd0) ctrl_d = ctrl_wv;
    if (we && idx == 2'd1) ctrl_d[26] = 1'b1;
    if (irq_raise)         ctrl_d[0] = 1'b1;
    else if (irq_ack)      ctrl_d[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      addr_q <= '0;
      sp2_q  <= '0;
      sp3_q  <= '0;
      rst_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      rst_q  <= we && idx == 2'd0 && wdata[7];
      if (we && idx == 2'd1)
        addr_q <= wdata;
      else if (xfer_done)
        addr_q <= addr_q + {{PAD{1'b0}}, xfer_len};
      if (we && idx == 2'd2) sp2_q <= wdata;
      if (we && idx == 2'd3) sp3_q <= wdata;
    end
  end

  always_comb begin
    case (idx)
      2'd0:    rdata = ctrl_q;
      2'd1:    rdata = addr_q;
      2'd2:    rdata = sp2_q;
      default: rdata = sp3_q;
    endcase
  end

  assign irq        = ctrl_q[0] & ctrl_q[4];
  assign periph_rst = rst_q;
  assign dir_to_mem = ctrl_q[8];
  assign loaded     = ctrl_q[26];
endmodule

module dmach_regs_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             we,
  input logic [3:0]       addr,
  input logic [31:0]      wdata,
  input logic             irq_raise,
  input logic             irq_ack,
  input logic             xfer_done,
  input logic [LEN_W-1:0] xfer_len,
  input logic             irq,
  input logic             periph_rst,
  input logic             loaded,
  input logic [31:0]      ctrl_q,
  input logic [31:0]      addr_q
);
  a_r2_version: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr[3:2] == 2'd0) |=> ctrl_q[31:28] == 4'hA);
  a_r3_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst |=> !periph_rst);
  a_r3_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr[3:2] == 2'd0 && wdata[7]) |=> periph_rst);
  a_r4_raise: assert property (@(posedge clk) disable iff (!rst_n)
    irq_raise |=> ctrl_q[0]);
  a_r4_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_raise) |=> !ctrl_q[0]);
  a_r5_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr[3:2] == 2'd0 && !wdata[4]) |=> !irq);
  a_r6_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr[3:2] == 2'd1) |=> loaded);
  a_r8_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !(we && addr[3:2] == 2'd1)) |=>
      addr_q == $past(addr_q) + 32'($past(xfer_len)));
endmodule

bind dmach_regs dmach_regs_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
  .irq_raise(irq_raise), .irq_ack(irq_ack), .xfer_done(xfer_done),
  .xfer_len(xfer_len), .irq(irq), .periph_rst(periph_rst), .loaded(loaded),
  .ctrl_q(ctrl_q), .addr_q(addr_q)
);

// File: tb/dmach_regs_tb.sv
module dmach_regs_tb_top;
  localparam int LEN_W = 16;

  logic             clk = 0, rst_n = 0, we = 0, irq_raise = 0, irq_ack = 0, xfer_done = 0;
  logic [3:0]       addr = 0;
  logic [31:0]      wdata = 0, rdata;
  logic [LEN_W-1:0] xfer_len = 0;
  logic             irq, periph_rst, dir_to_mem, loaded;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_w[4];
  logic        m_rst;

  always #5 clk = ~clk;

  dmach_regs #(.LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_raise(irq_raise), .irq_ack(irq_ack), .xfer_done(xfer_done),
    .xfer_len(xfer_len), .irq(irq), .periph_rst(periph_rst),
    .dir_to_mem(dir_to_mem), .loaded(loaded));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_w[i] = 0;
      m_rst = 0;
    end else begin
      logic [31:0] v;
      m_rst = 0;
      if (we) begin
        case (addr[3:2])
          2'd0: begin
            v = wdata;
            if (v[7]) m_rst = 1;
            else if (v[6]) v[6] = 0;
            else if (v == 0) v = 32'h40;
            v[31:28] = 4'hA;
            m_w[0] = v;
          end
          2'd1: begin m_w[1] = wdata; m_w[0][26] = 1; end
          default: m_w[addr[3:2]] = wdata;
        endcase
      end
      if (xfer_done && !(we && addr[3:2] == 2'd1)) m_w[1] = m_w[1] + 32'(xfer_len);
      if (irq_raise) m_w[0][0] = 1;
      else if (irq_ack) m_w[0][0] = 0;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic outs();
    chk("R5 irq", {31'b0, irq}, {31'b0, m_w[0][0] & m_w[0][4]});
    chk("R3 periph_rst", {31'b0, periph_rst}, {31'b0, m_rst});
    chk("R7 dir_to_mem", {31'b0, dir_to_mem}, {31'b0, m_w[0][8]});
    chk("R7 loaded", {31'b0, loaded}, {31'b0, m_w[0][26]});
  endtask

  task automatic cyc(logic w, logic [3:0] a, logic [31:0] d,
                     logic rs, logic ak, logic dn, logic [LEN_W-1:0] ln);
    @(negedge clk);
    outs();
    we = w; addr = a; wdata = d; irq_raise = rs; irq_ack = ak; xfer_done = dn; xfer_len = ln;
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0); endtask

  task automatic rd(string req, logic [3:0] a, logic [31:0] exp);
    idle();
    @(negedge clk);
    outs();
    addr = a;
    #1;
    chk(req, rdata, exp);
    chk({req, " model"}, rdata, m_w[a[3:2]]);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 periph_rst", {31'b0, periph_rst}, 0);
    for (int i = 0; i < 4; i++) begin
      addr = 4'(i * 4); #1; chk("R1 word", rdata, 0);
    end
    rst_n = 1;

    cyc(1, 4'h0, 32'h0, 0, 0, 0, 0);
    rd("R3 zero write", 4'h0, 32'hA000_0040);
    cyc(1, 4'h0, 32'h5123_4578, 0, 0, 0, 0);
    rd("R3 bit6 cleared", 4'h0, 32'hA123_4538);
    cyc(1, 4'h0, 32'h0000_00C0, 0, 0, 0, 0);
    @(negedge clk); outs(); we = 0;
    chk("R3 pulse high", {31'b0, periph_rst}, 1);
    @(negedge clk); outs();
    chk("R3 pulse one cycle", {31'b0, periph_rst}, 0);
    rd("R2 bit7 keeps bit6", 4'h0, 32'hA000_00C0);
    cyc(1, 4'h0, 32'hF000_0110, 0, 0, 0, 0);
    rd("R2 version nibble", 4'h0, 32'hA000_0110);

    cyc(0, 0, 0, 1, 0, 0, 0);
    idle();
    chk("R5 irq asserted", {31'b0, irq}, 1);
    cyc(1, 4'h0, 32'h0000_0101, 0, 0, 0, 0);
    idle();
    chk("R5 enable clear drops irq", {31'b0, irq}, 0);
    rd("R4 pending kept", 4'h0, 32'hA000_0101);
    cyc(1, 4'h0, 32'h0000_0111, 0, 1, 0, 0);
    rd("R4 ack beats write", 4'h0, 32'hA000_0110);
    cyc(1, 4'h0, 32'h0000_0110, 1, 0, 0, 0);
    rd("R4 raise beats write", 4'h0, 32'hA000_0111);
    cyc(0, 0, 0, 1, 1, 0, 0);
    rd("R4 raise and ack", 4'h0, 32'hA000_0111);
    cyc(0, 0, 0, 0, 1, 0, 0);
    rd("R4 ack clears", 4'h0, 32'hA000_0110);

    cyc(1, 4'h4, 32'h1000_0000, 0, 0, 0, 0);
    rd("R6 loaded set", 4'h0, 32'hA400_0110);
    rd("R6 address stored", 4'h5, 32'h1000_0000);
    cyc(0, 0, 0, 0, 0, 1, 16'h0200);
    rd("R8 advance", 4'h4, 32'h1000_0200);
    cyc(1, 4'h4, 32'hFFFF_FFF0, 0, 0, 1, 16'h0100);
    rd("R8 write beats advance", 4'h4, 32'hFFFF_FFF0);
    cyc(0, 0, 0, 0, 0, 1, 16'h0020);
    rd("R8 wrap", 4'h4, 32'h0000_0010);
    cyc(1, 4'h0, 32'h0000_0012, 0, 0, 1, 16'h0004);
    rd("R8 advance with ctrl write", 4'h4, 32'h0000_0014);

    cyc(1, 4'h8, 32'hDEAD_BEEF, 0, 0, 0, 0);
    cyc(1, 4'hF, 32'h0000_0000, 0, 0, 0, 0);
    rd("R9 spare2", 4'hA, 32'hDEAD_BEEF);
    rd("R9 spare3", 4'hC, 32'h0);
    rd("R9 read repeat", 4'h8, 32'hDEAD_BEEF);
    rd("R9 ctrl untouched", 4'h0, 32'hA000_0012);

    for (int i = 0; i < 40; i++) begin
      cyc(1'($urandom_range(0, 1)), 4'($urandom), $urandom,
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), 16'($urandom));
    end
    for (int i = 0; i < 4; i++) rd("R9 random read", 4'(i * 4), m_w[i]);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule